// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block works out where a 32-bit RISC core fetches next after a control-transfer instruction. It takes the address of the current instruction, the instruction word, one integer register value, the floating-point compare flag and a small class code from the decoder. From these it decides whether the transfer is taken, forms the target address, and reports whether register 31 receives a return address. All arithmetic starts from the address of the current instruction, before any increment. Offsets are relative to the following instruction (PC+4), and the return address is PC+8.

The decoder supplies the class code. The unit decodes the source register index from the instruction word itself and presents it on `src_idx`, so the register file can return `src_val` in the same cycle. Results are registered once: a transfer sampled with `in_valid` high at a rising edge appears on the outputs after that edge. Flushing and exceptions are handled elsewhere.

Top module: `xfer_npc`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `out_valid`=0, `taken`=0, `link_we`=0, `link_data`=0 and `next_pc`=`RESET_PC` (default 0).
- R2: `out_valid` equals `in_valid` as sampled at the previous rising edge. A cycle with `in_valid`=0 gives `taken`=0 and `link_we`=0.
- R3: Class 1 (branch if zero) is taken when `src_val` is 0. The target is `pc` + 4 + the sign-extended `instr[15:0]`.
- R4: Class 2 (branch if nonzero) is taken when `src_val` is not 0. The target is formed the same way as in R3.
- R5: Class 3 is taken when `fp_flag` is 1, and class 4 is taken when `fp_flag` is 0. Both use the R3 target.
- R6: Class 5 (relative jump) is always taken. The target is `pc` + 4 + the sign-extended `instr[25:0]`, including negative offsets.
- R7: Class 6 (relative jump with link) jumps as in R6. It also sets `link_we`=1 with `link_data`=`pc`+8 and `link_rd`=31.
- R8: Class 7 (register jump) is always taken. The target is `src_val` unchanged, with no masking or extension.
- R9: Class 8 (register jump with link) targets the `src_val` presented in the same cycle, which is the value before the link write. It writes `pc`+8 to register 31.
- R10: An untaken branch, class 0, or any class code from 9 to 15 gives `next_pc`=`pc`+4, `taken`=0 and `link_we`=0.
- R11: All address sums wrap modulo 2^32.
- R12: `src_idx` always equals `instr[25:21]`, which are bits 6..10 when bits are counted from the most significant end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 4 | Control-transfer class from the decoder (0 = none) |
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Value of the register selected by `src_idx` |
| fp_flag | input | 1 | Floating-point compare status |
| src_idx | output | 5 | Source register index decoded from the instruction |
| out_valid | output | 1 | Registered result is valid |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | Transfer redirected the PC |
| link_we | output | 1 | Return address write to the link register |
| link_rd | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address, PC+8 |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, 16-bit and 26-bit offsets and a 5-bit register index. With these values the offset sign bits sit at bits 15 and 25. The bench can then aim all-ones offsets at low addresses and check the wrap, and drive PC values near 2^32 so that PC+4 and PC+8 overflow. Random class codes cover the unused codes 9 to 15. Random gaps in `in_valid` exercise the idle outputs.

// File: rtl/xfer_npc_pkg.sv
package xfer_npc_pkg;
  localparam int CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    XF_NONE     = 4'd0,
    XF_BR_ZERO  = 4'd1,
    XF_BR_NZERO = 4'd2,
    XF_BR_FPT   = 4'd3,
    XF_BR_FPF   = 4'd4,
    XF_JREL     = 4'd5,
    XF_JREL_LNK = 4'd6,
    XF_JREG     = 4'd7,
    XF_JREG_LNK = 4'd8
  } xfer_cls_e;

  typedef struct packed {
    logic take;
    logic use_reg;
    logic use_long;
    logic do_link;
  } xfer_ctl_t;
endpackage

// File: rtl/xfer_npc_cond.sv
module xfer_npc_cond
  import xfer_npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CLS_W-1:0] cls_raw,
  input  logic [XLEN-1:0]  reg_val,
  input  logic             fp_flag,
  output xfer_ctl_t        ctl
);
  logic is_zero;
  assign is_zero = (reg_val == '0);

  always_comb begin
    ctl = '0;
    unique case (cls_raw)
      XF_BR_ZERO:  ctl.take = is_zero;
      XF_BR_NZERO: ctl.take = !is_zero;
      XF_BR_FPT:   ctl.take = fp_flag;
      XF_BR_FPF:   ctl.take = !fp_flag;
      XF_JREL: begin
        ctl.take     = 1'b1;
        ctl.use_long = 1'b1;
      end
      XF_JREL_LNK: begin
        ctl.take     = 1'b1;
        ctl.use_long = 1'b1;
        ctl.do_link  = 1'b1;
      end
      XF_JREG: begin
        ctl.take    = 1'b1;
        ctl.use_reg = 1'b1;
      end
      XF_JREG_LNK: begin
        ctl.take    = 1'b1;
        ctl.use_reg = 1'b1;
        ctl.do_link = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/xfer_npc_target.sv
module xfer_npc_target
  import xfer_npc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] reg_val,
  input  xfer_ctl_t       ctl,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_val
);
  localparam int SEXT_S = XLEN - SHORT_W;
  localparam int SEXT_L = XLEN - LONG_W;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] off_short;
  logic [XLEN-1:0] off_long;
  logic [XLEN-1:0] rel_tgt;

  assign off_short = {{SEXT_S{instr[SHORT_W-1]}}, instr[SHORT_W-1:0]};
  assign off_long  = {{SEXT_L{instr[LONG_W-1]}},  instr[LONG_W-1:0]};

  assign seq_pc   = pc + XLEN'(4);
  assign link_val = pc + XLEN'(8);
  assign rel_tgt  = seq_pc + (ctl.use_long ? off_long : off_short);

  always_comb begin
    if (!ctl.take)       next_pc = seq_pc;
    else if (ctl.use_reg) next_pc = reg_val;
    else                 next_pc = rel_tgt;
  end
endmodule

// File: rtl/xfer_npc.sv
module xfer_npc
  import xfer_npc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          SHORT_W  = 16,
  parameter int          LONG_W   = 26,
  parameter int          REG_AW   = 5,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_class,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   src_val,
  input  logic              fp_flag,
  output logic [REG_AW-1:0] src_idx,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [REG_AW-1:0] link_rd,
  output logic [XLEN-1:0]   link_data
);
  localparam int              SRC_MSB  = XLEN - 7;
  localparam logic [REG_AW-1:0] LINK_IDX = {REG_AW{1'b1}};

  xfer_ctl_t       ctl;
  logic [XLEN-1:0] npc_d;
  logic [XLEN-1:0] link_d;

  assign src_idx = instr[SRC_MSB -: REG_AW];
  assign link_rd = LINK_IDX;

  xfer_npc_cond #(.XLEN(XLEN)) u_cond (
    .cls_raw (op_class),
    .reg_val (src_val),
    .fp_flag (fp_flag),
    .ctl     (ctl)
  );

  xfer_npc_target #(.XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_tgt (
    .pc       (pc),
    .instr    (instr),
    .reg_val  (src_val),
    .ctl      (ctl),
    .next_pc  (npc_d),
    .link_val (link_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      next_pc   <= XLEN'(RESET_PC);
      taken     <= 1'b0;
      link_we   <= 1'b0;
      link_data <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc   <= npc_d;
        taken     <= ctl.take;
        link_we   <= ctl.do_link;
        link_data <= link_d;
      end else begin
        taken   <= 1'b0;
        link_we <= 1'b0;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !taken && !link_we));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!taken && !link_we));

  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> (next_pc == $past(pc) + XLEN'(4)));

  assert_link_value_R7: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (taken && link_data == $past(pc) + XLEN'(8)));

  assert_jreg_target_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_class == 4'd7 || op_class == 4'd8)) |=> (taken && next_pc == $past(src_val)));
endmodule

// File: tb/sim_xfer_npc.sv
`timescale 1ns/1ps
module sim_xfer_npc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_class = '0;
  logic [31:0] pc = '0, instr = '0, src_val = '0;
  logic        fp_flag = 1'b0;
  logic [4:0]  src_idx, link_rd;
  logic        out_valid, taken, link_we;
  logic [31:0] next_pc, link_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xfer_npc u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
    .pc(pc), .instr(instr), .src_val(src_val), .fp_flag(fp_flag),
    .src_idx(src_idx), .out_valid(out_valid), .next_pc(next_pc),
    .taken(taken), .link_we(link_we), .link_rd(link_rd), .link_data(link_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int c);
    case (c)
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int c, input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] rv, input logic fps,
                       output logic [31:0] npc, output logic tk, output logic lk);
    logic [31:0] s16, s26;
    s16 = {{16{ins[15]}}, ins[15:0]};
    s26 = {{6{ins[25]}}, ins[25:0]};
    lk = (c == 6) || (c == 8);
    case (c)
      1: tk = (rv == 0);
      2: tk = (rv != 0);
      3: tk = fps;
      4: tk = !fps;
      5, 6, 7, 8: tk = 1'b1;
      default: tk = 1'b0;
    endcase
    if (!tk)                 npc = p + 32'd4;
    else if (c == 7 || c == 8) npc = rv;
    else if (c == 5 || c == 6) npc = p + 32'd4 + s26;
    else                     npc = p + 32'd4 + s16;
  endtask

  // Drive at a negedge, let one posedge register, check at the following negedge.
  task automatic xact(input logic v, input int c, input logic [31:0] p,
                      input logic [31:0] ins, input logic [31:0] rv, input logic fps);
    logic [31:0] e_npc;
    logic        e_tk, e_lk;
    string       r;
    @(negedge clk);
    in_valid = v; op_class = 4'(c); pc = p; instr = ins; src_val = rv; fp_flag = fps;
    #1;
    chk("R12 src_idx", {27'd0, src_idx}, {27'd0, ins[25:21]});
    model(c, p, ins, rv, fps, e_npc, e_tk, e_lk);
    r = req_of(c);
    @(negedge clk);
    chk("R2 out_valid", {31'd0, out_valid}, {31'd0, v});
    if (v) begin
      chk({r, " next_pc"}, next_pc, e_npc);
      chk({r, " taken"}, {31'd0, taken}, {31'd0, e_tk});
      chk({r, " link_we"}, {31'd0, link_we}, {31'd0, e_lk});
      if (e_lk) begin
        chk({r, " link_data"}, link_data, p + 32'd8);
        chk({r, " link_rd"}, {27'd0, link_rd}, 32'd31);
      end
    end else begin
      chk("R2 idle taken", {31'd0, taken}, 32'd0);
      chk("R2 idle link_we", {31'd0, link_we}, 32'd0);
    end
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] rs;
    rs = $urandom(32'd7531);
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 next_pc", next_pc, 32'd0);
    chk("R1 taken", {31'd0, taken}, 32'd0);
    chk("R1 link_we", {31'd0, link_we}, 32'd0);
    chk("R1 link_data", link_data, 32'd0);
    rst = 1'b0;

    // R3 zero taken, negative offset; R4 not taken on zero
    xact(1, 1, 32'h0000_0100, 32'h0000_FFF0, 32'd0, 0);
    xact(1, 1, 32'h0000_0100, 32'h0000_0010, 32'd5, 0);
    xact(1, 2, 32'h0000_2000, 32'h0000_8000, 32'd1, 0);
    xact(1, 2, 32'h0000_2000, 32'h0000_8000, 32'd0, 0);
    // R5 fp branches both polarities
    xact(1, 3, 32'h0000_0040, 32'h0000_0020, 32'd0, 1);
    xact(1, 3, 32'h0000_0040, 32'h0000_0020, 32'd0, 0);
    xact(1, 4, 32'h0000_0040, 32'h0000_FFFC, 32'd0, 0);
    xact(1, 4, 32'h0000_0040, 32'h0000_FFFC, 32'd0, 1);
    // R6 jump by -4 lands on itself; R11 wrap past zero
    xact(1, 5, 32'h0000_1000, 32'h03FF_FFFC, 32'd0, 0);
    xact(1, 5, 32'h0000_0008, 32'h03FF_FF00, 32'd0, 0);
    // R7 link, R11 link wraps
    xact(1, 6, 32'hFFFF_FFFC, 32'h0000_0100, 32'd0, 0);
    // R8 odd unsigned target kept as is
    xact(1, 7, 32'h0000_0500, 32'h0060_0000, 32'h8000_0003, 0);
    // R9 source is old r31 value, not the new link
    xact(1, 8, 32'h0000_0300, 32'h03E0_0000, 32'h0000_0abc, 0);
    // R10 none and unused codes, R11 sequential wrap
    xact(1, 0, 32'hFFFF_FFFC, 32'h0000_0000, 32'd0, 0);
    xact(1, 9, 32'h0000_0010, 32'h03FF_FFFF, 32'd0, 1);
    xact(1, 15, 32'h0000_0010, 32'h03FF_FFFF, 32'd0, 1);
    // R2 idle gap
    xact(0, 5, 32'h0000_0010, 32'h0000_0100, 32'd0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] p, ins, rv;
      p   = $urandom;
      ins = $urandom;
      rv  = ($urandom % 4 == 0) ? 32'd0 : $urandom;
      xact(($urandom % 8) != 0, int'($urandom % 16), p, ins, rv, 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule